// File: doc/BRIEF.md
# Parallel Configuration Port Loader

This block is the master side of a parallel slave configuration port. It takes a bitstream as a stream of words over a valid/ready handshake and writes it into a target device. To do this it drives the program strobe, the chip select, the write/read select, a configuration clock and an 8- or 16-bit data bus. It watches the target's INIT and DONE status lines and brings both in through two-flop synchronisers.

A load starts with a pulse on `start`. The loader then pulses the program strobe and waits for INIT to go low and come back high. Next it selects write, and only after that does it lower the chip select and send words. The target captures one word on each rising edge of the configuration clock. The clock is derived from the system clock through a divider.

When upstream stalls, the loader pauses in one of two ways. In free-running mode it raises the chip select for a period. In controlled mode, selected with `pause_by_clock`, it holds the clock low. A pause is never taken by raising the chip select while the sync word is passing or during the two words after it. After the last word the loader keeps clocking until DONE is high, and then releases the chip select before the write/read select.

Top module: `cfg_port_loader`

## Requirements
- R1: A `start` pulse drives `prog_n` low for PROG_CYCLES system clocks. `cclk` does not toggle and `cs_n` stays high until `init_in` has been seen low and then high.
- R2: `rdwr_n` goes low at least one cycle before `cs_n` falls. It never changes while `cs_n` is low.
- R3: Every word accepted with `s_valid && s_ready` appears on `d_out` with `cs_n` low for exactly one rising edge of `cclk`. Words are captured in acceptance order, with none lost or repeated.
- R4: The high half of `cclk` lasts CLK_DIV system clocks and the low half lasts at least CLK_DIV. `d_out` and `cs_n` change only while `cclk` is low, and at least CLK_DIV system clocks before the next rising edge.
- R5: With `pause_by_clock`=0, a stall outside the guarded window raises `cs_n` for one `cclk` period while the clock keeps running.
- R6: With `pause_by_clock`=1, a stall holds `cclk` low, and `cs_n` never rises between the first word and the end of the load.
- R7: The sync word is 0xAA995566, sent most significant part first: four bytes 0xAA, 0x99, 0x55, 0x66 when DATA_W=8, or two halfwords 0xAA99, 0x5566 when DATA_W=16. From the word after its first part until two words after its last part is captured, `cs_n` stays low on every rising edge. A stall in that window holds the clock in either mode.
- R8: After the word marked `s_last` is captured, at least STARTUP_MIN further rising edges occur. Clocking continues until `done_in` is high. Then `cs_n` rises, `rdwr_n` rises in a later cycle, and `finished` goes high.
- R9: If INIT does not return high within INIT_TIMEOUT system clocks of the program pulse ending, `error` goes high and `cs_n` and `rdwr_n` stay high.
- R10: If DONE is still low after DONE_TIMEOUT rising edges following the last word, `error` goes high after exactly that many edges. `cs_n` is released before `rdwr_n`.
- R11: After reset, `prog_n`, `cs_n` and `rdwr_n` are high, and `cclk`, `s_ready`, `busy`, `finished` and `error` are low.
- R12: `s_ready` is high only while `cclk` is low, during the data phase, and after INIT has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (honoured when idle, finished or in error) |
| pause_by_clock | input | 1 | 1 = stall by holding the clock, 0 = stall by raising chip select |
| s_data | input | DATA_W | Bitstream word |
| s_valid | input | 1 | Word available |
| s_last | input | 1 | Word is the final (startup) word |
| s_ready | output | 1 | Word taken on this cycle when valid |
| prog_n | output | 1 | Program strobe, active low |
| cs_n | output | 1 | Chip select, active low |
| rdwr_n | output | 1 | Write/read select, low = write |
| cclk | output | 1 | Configuration clock |
| d_out | output | DATA_W | Configuration data bus |
| init_in | input | 1 | Target INIT status line |
| done_in | input | 1 | Target DONE status line |
| busy | output | 1 | A load is in progress |
| finished | output | 1 | Load completed |
| error | output | 1 | INIT or DONE timeout occurred |

## Verification
The first stimulus is an unbroken stream. It shows that capture order and clock shape are right when no pause logic is involved. Gapped streams in free-running mode separate pausing by chip select from holding the clock: a gap before the sync word must produce a high-select edge, while gaps inside the sync word and just after it must stretch the low half of the clock. The same gaps in controlled mode must never produce a high-select edge. Separate runs raise DONE early, raise it late, and keep INIT or DONE low forever, which tells the minimum startup count apart from waiting on DONE and from both timeouts.

// File: rtl/cfg_port_loader.sv
module cfg_port_loader #(
  parameter int          DATA_W       = 8,
  parameter int          CLK_DIV      = 2,
  parameter int          PROG_CYCLES  = 16,
  parameter int          INIT_TIMEOUT = 100000,
  parameter int          STARTUP_MIN  = 8,
  parameter int          DONE_TIMEOUT = 1000,
  parameter logic [31:0] SYNC         = 32'hAA995566
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pause_by_clock,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              prog_n,
  output logic              cs_n,
  output logic              rdwr_n,
  output logic              cclk,
  output logic [DATA_W-1:0] d_out,
  input  logic              init_in,
  input  logic              done_in,
  output logic              busy,
  output logic              finished,
  output logic              error
);
  localparam int WORDS = 32 / DATA_W;
  localparam int CW    = $clog2(CLK_DIV + 1);
  localparam int TW    = $clog2(PROG_CYCLES + INIT_TIMEOUT + 1);
  localparam int RW    = $clog2(DONE_TIMEOUT + 1);

  typedef enum logic [3:0] {S_IDLE, S_PROG, S_WINIT, S_SETUP, S_LOAD, S_START, S_REL, S_FIN, S_ERR} st_t;

  st_t               st;
  logic [1:0]        init_sq, done_sq;
  logic [CW-1:0]     cnt;
  logic [TW-1:0]     tcnt;
  logic [RW-1:0]     rcnt;
  logic              cclk_q, cs_q, rw_q, prog_q, want, last_sent, synced, init_lo;
  logic [1:0]        post;
  logic [DATA_W-1:0] d_q;
  logic [31:0]       hist;
  logic [WORDS-2:0]  pm;

  wire init_s   = init_sq[1];
  wire done_s   = done_sq[1];
  wire tick     = (cnt == '0);
  wire [31:0] hist_nx = {hist[31-DATA_W:0], s_data};
  wire sync_hit = (hist_nx == SYNC);

  for (genvar k = 1; k < WORDS; k++) begin : g_prefix
    assign pm[k-1] = (hist[k*DATA_W-1:0] == SYNC[31 -: k*DATA_W]);
  end

  wire guard    = synced ? (post != 2'd0) : (|pm);
  wire can_skip = !pause_by_clock && !guard;

  assign s_ready  = (st == S_LOAD) && want && !cclk_q;
  wire   accept   = s_valid && s_ready;

  assign prog_n   = prog_q;
  assign cs_n     = cs_q;
  assign rdwr_n   = rw_q;
  assign cclk     = cclk_q;
  assign d_out    = d_q;
  assign finished = (st == S_FIN);
  assign error    = (st == S_ERR);
  assign busy     = !(st == S_IDLE || st == S_FIN || st == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      init_sq   <= '0;
      done_sq   <= '0;
      cnt       <= '0;
      tcnt      <= '0;
      rcnt      <= '0;
      cclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      rw_q      <= 1'b1;
      prog_q    <= 1'b1;
      want      <= 1'b0;
      last_sent <= 1'b0;
      synced    <= 1'b0;
      init_lo   <= 1'b0;
      post      <= '0;
      d_q       <= '0;
      hist      <= '0;
    end else begin
      init_sq <= {init_sq[0], init_in};
      done_sq <= {done_sq[0], done_in};
      case (st)
        S_IDLE, S_FIN, S_ERR: begin
          cs_q   <= 1'b1;
          cclk_q <= 1'b0;
          prog_q <= 1'b1;
          if (cs_q) rw_q <= 1'b1;
          if (start && cs_q && rw_q) begin
            st      <= S_PROG;
            prog_q  <= 1'b0;
            tcnt    <= '0;
            init_lo <= 1'b0;
          end
        end
        S_PROG: begin
          tcnt <= tcnt + 1'b1;
          if (!init_s) init_lo <= 1'b1;
          if (tcnt == TW'(PROG_CYCLES - 1)) begin
            prog_q <= 1'b1;
            tcnt   <= '0;
            st     <= S_WINIT;
          end
        end
        S_WINIT: begin
          tcnt <= tcnt + 1'b1;
          if (!init_s) init_lo <= 1'b1;
          if (init_s && init_lo) begin
            rw_q <= 1'b0;
            st   <= S_SETUP;
          end else if (tcnt == TW'(INIT_TIMEOUT - 1)) begin
            st <= S_ERR;
          end
        end
        S_SETUP: begin
          st        <= S_LOAD;
          want      <= 1'b1;
          cnt       <= CW'(CLK_DIV - 1);
          cclk_q    <= 1'b0;
          last_sent <= 1'b0;
          hist      <= '0;
          synced    <= 1'b0;
          post      <= '0;
        end
        S_LOAD: begin
          if (!cclk_q) begin
            if (want) begin
              if (accept) begin
                d_q       <= s_data;
                cs_q      <= 1'b0;
                want      <= 1'b0;
                cnt       <= CW'(CLK_DIV - 1);
                last_sent <= s_last;
                hist      <= hist_nx;
                if (!synced && sync_hit) begin
                  synced <= 1'b1;
                  post   <= 2'd2;
                end else if (post != 2'd0) begin
                  post <= post - 2'd1;
                end
              end else if (can_skip) begin
                cs_q <= 1'b1;
                want <= 1'b0;
                cnt  <= CW'(CLK_DIV - 1);
              end
            end else if (tick) begin
              cclk_q <= 1'b1;
              cnt    <= CW'(CLK_DIV - 1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end else if (tick) begin
            cclk_q <= 1'b0;
            cnt    <= CW'(CLK_DIV - 1);
            if (last_sent) begin
              st   <= S_START;
              rcnt <= '0;
            end else begin
              want <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_START: begin
          if (!cclk_q) begin
            if (tick) begin
              cclk_q <= 1'b1;
              cnt    <= CW'(CLK_DIV - 1);
              rcnt   <= rcnt + 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end else if (tick) begin
            cclk_q <= 1'b0;
            cnt    <= CW'(CLK_DIV - 1);
            if (rcnt >= RW'(STARTUP_MIN) && done_s) st <= S_REL;
            else if (rcnt >= RW'(DONE_TIMEOUT))     st <= S_ERR;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_REL: begin
          cs_q <= 1'b1;
          if (cs_q) begin
            rw_q <= 1'b1;
            st   <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cfg_port_loader_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_n,
  input logic              cs_n,
  input logic              rdwr_n,
  input logic              cclk,
  input logic [DATA_W-1:0] d_out,
  input logic              s_ready,
  input logic              finished,
  input logic              error
);
  // R2
  cs_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !rdwr_n);
  // R2
  select_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!rdwr_n));
  // R8
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdwr_n) |-> (cs_n && $past(cs_n)));
  // R4
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> ($stable(d_out) && $stable(cs_n)));
  // R1
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (cs_n && !cclk));
  // R12
  ready_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!cclk && prog_n));
  // R9
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(finished && error));
endmodule

bind cfg_port_loader cfg_port_loader_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cfg_port_loader_tb.sv
module cfg_port_loader_tb;
  localparam int DW   = 8;
  localparam int DIV  = 2;
  localparam int PROG = 4;
  localparam int ITO  = 300;
  localparam int SMIN = 8;
  localparam int DTO  = 40;
  localparam int NW   = 16;
  localparam int SPOS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pbc = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic init_in = 1'b1, done_in = 1'b0;
  logic s_ready, prog_n, cs_n, rdwr_n, cclk, busy, finished, error;
  logic [DW-1:0] d_out;

  cfg_port_loader #(.DATA_W(DW), .CLK_DIV(DIV), .PROG_CYCLES(PROG), .INIT_TIMEOUT(ITO),
                    .STARTUP_MIN(SMIN), .DONE_TIMEOUT(DTO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pause_by_clock(pbc),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .prog_n(prog_n), .cs_n(cs_n), .rdwr_n(rdwr_n), .cclk(cclk), .d_out(d_out),
    .init_in(init_in), .done_in(done_in), .busy(busy), .finished(finished), .error(error));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit mon_en = 0, gaps_on = 0, stop_feed = 0;
  int init_dly, done_after, init_cnt;
  bit seen_prog, init_ready, last_cap, done_at_rel;
  int cap [0:NW-1];
  int ncap, st_rises, rel_rises, cs_pause, long_lo, win_hold, prog_len;
  int v_order, v_rel, v_init, v_setup, v_guard, v_ready;
  int hi_len, lo_len, since;
  logic p_cclk, p_cs, p_rw;
  logic [DW-1:0] p_d;

  function automatic logic [DW-1:0] word(int i);
    case (i)
      0, 1: return 8'hFF;
      2: return 8'hAA;
      3: return 8'h99;
      4: return 8'h55;
      5: return 8'h66;
      default: return DW'((i * 29 + 7) & 255);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        chk(1'b0, "R0", "watchdog expired", cyc, 190000);
        summary();
        $finish;
      end
    end
  end

  // target model and protocol rules, evaluated every clock
  initial begin
    p_cclk = 0; p_cs = 1; p_rw = 1; p_d = '0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        bit rise, fall, chg;
        rise = cclk && !p_cclk;
        fall = !cclk && p_cclk;
        chg  = (d_out != p_d) || (cs_n != p_cs);
        if (chg) since = 0; else since++;
        if (!prog_n) prog_len++;
        if (!cs_n && rdwr_n) v_order++;
        if (!p_cs && !cs_n && rdwr_n != p_rw) v_order++;
        if (p_cs && !cs_n && p_rw) v_order++;
        if (rdwr_n && !p_rw && (!p_cs || !cs_n)) v_rel++;
        if ((!cs_n || rise) && !init_ready) v_init++;
        if (s_ready && (cclk || !init_ready || !prog_n)) v_ready++;
        if (rise) begin
          if (since < DIV) v_setup++;
          if (lo_len < DIV) v_setup++;
          if (!cs_n) begin
            if (lo_len > DIV + 1 && ncap > 0 && !last_cap) long_lo++;
            if (lo_len > DIV + 1 && ncap >= SPOS + 1 && ncap <= SPOS + 5) win_hold++;
            if (!last_cap) begin
              cap[ncap] = int'(d_out);
              ncap++;
              if (ncap == NW) last_cap = 1;
            end else st_rises++;
          end else if (ncap > 0 && !last_cap) begin
            cs_pause++;
            if (ncap >= SPOS + 1 && ncap <= SPOS + 5) v_guard++;
          end
          hi_len = 1;
        end else if (cclk) hi_len++;
        if (fall) begin
          if (hi_len != DIV) v_setup++;
          lo_len = 1;
        end else if (!cclk) lo_len++;
        if (cs_n && !p_cs && last_cap) begin
          done_at_rel = done_in;
          rel_rises   = st_rises;
        end
        if (!prog_n) begin
          init_in = 0; done_in = 0; init_ready = 0; init_cnt = 0; seen_prog = 1;
        end else if (seen_prog && !init_ready && init_dly >= 0) begin
          init_cnt++;
          if (init_cnt >= init_dly) begin
            init_in = 1;
            init_ready = 1;
          end
        end
        if (last_cap && done_after >= 0 && st_rises >= done_after) done_in = 1;
      end
      p_cclk = cclk; p_cs = cs_n; p_rw = rdwr_n; p_d = d_out;
    end
  end

  task automatic feed();
    for (int i = 0; i < NW && !stop_feed; i++) begin
      int g;
      bit hs;
      g = (gaps_on && (i % 3 == 1)) ? 9 : 0;
      repeat (g) begin
        @(negedge clk);
        s_valid = 0;
      end
      @(negedge clk);
      s_valid = 1; s_data = word(i); s_last = (i == NW - 1);
      hs = 0;
      while (!hs && !stop_feed) begin
        #4;
        hs = s_ready;
        if (!hs) @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  int elapsed;

  task automatic run(input bit ctl, input bit gaps, input int idly, input int dafter);
    int t;
    ncap = 0; st_rises = 0; rel_rises = -1; cs_pause = 0; long_lo = 0; win_hold = 0; prog_len = 0;
    v_order = 0; v_rel = 0; v_init = 0; v_setup = 0; v_guard = 0; v_ready = 0;
    hi_len = 0; lo_len = 100; since = 100; last_cap = 0; done_at_rel = 0;
    seen_prog = 0; init_ready = 0; init_dly = idly; done_after = dafter;
    pbc = ctl; gaps_on = gaps; stop_feed = 0;
    @(negedge clk); start = 1; mon_en = 1;
    @(negedge clk); start = 0;
    fork feed(); join_none
    t = 0;
    while (!(finished || error) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    stop_feed = 1;
    repeat (3) @(negedge clk);
    mon_en = 0;
    elapsed = t;
  endtask

  function automatic int mism();
    int m = 0;
    for (int i = 0; i < NW; i++) if (i >= ncap || cap[i] != int'(word(i))) m++;
    return m;
  endfunction

  task automatic common(input string tag);
    chk(v_order == 0, "R2", {tag, " select ordering violations"}, v_order, 0);
    chk(v_rel == 0, "R8", {tag, " release ordering violations"}, v_rel, 0);
    chk(v_init == 0, "R1", {tag, " activity before INIT high"}, v_init, 0);
    chk(v_setup == 0, "R4", {tag, " clock shape or setup violations"}, v_setup, 0);
    chk(v_ready == 0, "R12", {tag, " ready outside data phase"}, v_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(prog_n && cs_n && rdwr_n && !cclk, "R11", "pins idle after reset", {prog_n, cs_n, rdwr_n, cclk}, 4'b1110);
    chk(!s_ready && !busy && !finished && !error, "R11", "status low after reset",
        {s_ready, busy, finished, error}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // continuous stream, free-running, DONE early
    run(0, 0, 6, 3);
    chk(prog_len == PROG, "R1", "program pulse length", prog_len, PROG);
    chk(ncap == NW && mism() == 0, "R3", "continuous capture", mism(), 0);
    chk(cs_pause == 0, "R5", "no pause on unbroken stream", cs_pause, 0);
    chk(rel_rises >= SMIN, "R8", "minimum startup edges", rel_rises, SMIN);
    chk(finished && !error && rdwr_n && cs_n, "R8", "finished with lines released", {finished, error}, 2);
    common("cont");

    // gapped stream, free-running, DONE late
    run(0, 1, 3, 20);
    chk(ncap == NW && mism() == 0, "R3", "free-mode capture", mism(), 0);
    chk(cs_pause > 0, "R5", "chip select pauses", cs_pause, 1);
    chk(v_guard == 0, "R7", "free-mode guard violations", v_guard, 0);
    chk(win_hold > 0, "R7", "clock held inside guard", win_hold, 1);
    chk(rel_rises >= 20 && done_at_rel, "R8", "waited for DONE", rel_rises, 20);
    chk(finished && !error, "R8", "free-mode finish", {finished, error}, 2);
    common("free");

    // gapped stream, controlled clock
    run(1, 1, 5, 0);
    chk(ncap == NW && mism() == 0, "R3", "controlled capture", mism(), 0);
    chk(cs_pause == 0, "R6", "no select pause", cs_pause, 0);
    chk(long_lo > 0, "R6", "clock held on stall", long_lo, 1);
    chk(v_guard == 0, "R7", "controlled guard violations", v_guard, 0);
    chk(finished && !error, "R6", "controlled finish", {finished, error}, 2);
    common("ctl");

    // INIT never returns
    run(0, 0, -1, 0);
    chk(error && !finished, "R9", "init timeout flag", {error, finished}, 2);
    chk(cs_n && rdwr_n && prog_n && ncap == 0, "R9", "lines idle after init timeout", ncap, 0);
    chk(elapsed >= ITO, "R9", "timeout not early", elapsed, ITO);
    common("itmo");

    // DONE never rises
    run(0, 0, 4, -1);
    chk(error && !finished, "R10", "done timeout flag", {error, finished}, 2);
    chk(st_rises == DTO, "R10", "edges before done timeout", st_rises, DTO);
    chk(cs_n && rdwr_n, "R10", "lines released after done timeout", {cs_n, rdwr_n}, 3);
    common("dtmo");

    summary();
    $finish;
  end
endmodule